// File: doc/BRIEF.md
# Dual-Channel PWM Slice with Phase-Correct Counting

This block generates two pulse-width-modulated outputs, A and B, from one shared counter. The counter moves only on clock cycles where an external tick input is high. That tick normally comes from a fractional clock divider outside the block, so the divider ratio sets how the period maps onto system clocks. Each channel compares its own threshold against the counter and can invert its output. A slice enable starts and stops the whole slice.

The counter runs in one of two modes. In normal mode it counts up to a programmable top value and then drops back to 0, giving a period of top+1 ticks. In phase-correct mode it counts up to top and then back down to 0, dwelling one tick at each end. This gives a period of 2*(top+1) ticks, so pulses stay centred whatever the duty. A synchronous configuration port writes the threshold and top values into pending registers. They reach the counting logic only at a period boundary, so a period is never built from a mix of old and new values. A one-clock wrap pulse marks each period boundary.

Top module: `pwm_slice`

## Requirements
- R1: After reset the count is 0, both channel outputs are low, the wrap pulse is low and every configuration value is 0.
- R2: A write on the configuration port goes to the register picked by `cfg_sel`: 0 = top, 1 = threshold A, 2 = threshold B, 3 = control. In the control word, bit 0 is enable, bit 1 is phase-correct, bit 2 inverts A and bit 3 inverts B. A control write acts from the next clock.
- R3: The count changes only on a clock where the slice is enabled and `tick` is high. On any other clock it holds its value.
- R4: In normal mode, each tick adds one to the count. A tick taken while the count is at or above the active top sets the count to 0. The period is top+1 ticks.
- R5: In phase-correct mode the count rises to top, holds top for one tick while it reverses, falls to 0, and holds 0 for one tick while it reverses again. The period is 2*(top+1) ticks.
- R6: While the slice is enabled, a channel output is computed from the count and the active threshold of the previous clock. The value is high when the threshold is greater than the count, XOR that channel's invert bit.
- R7: With inversion off, a threshold of 0 keeps the output low for the whole period, and a threshold of top+1 keeps it high for the whole period.
- R8: While the slice is disabled, both outputs are low on the following clock whatever the invert bits say.
- R9: Written top and threshold values stay pending. They are copied to the active set on the clock of a wrap step, and on every clock while the slice is disabled. At no other time does the active set change.
- R10: `wrap` is high for one clock after each wrap step: normal mode top→0, or the phase-correct turnaround at 0. The count is 0 whenever `wrap` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter advance enable from the divider |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | CW | Configuration write data |
| count | output | CW | Current counter value |
| pwm_a | output | 1 | Channel A output |
| pwm_b | output | 1 | Channel B output |
| wrap | output | 1 | One-clock period-boundary pulse |

## Verification
The hardest case to reach is a configuration write that lands while the slice is disabled or mid-period. The pending value must then wait for the exact wrap tick, including the phase-correct turnaround at 0. That tick only happens when enable, tick and the count all line up. Random stimulus uses small top values, a sparse tick and frequent writes to every register, so pending values often straddle wrap steps and enable toggles. A step-by-step reference model checks every clock. Directed runs then measure the period in both modes, the always-low and always-high thresholds, and the outputs while disabled with inversion set.

// File: rtl/pwm_slice_pkg.sv
package pwm_slice_pkg;

    localparam logic [1:0] SEL_TOP   = 2'd0;
    localparam logic [1:0] SEL_CMP_A = 2'd1;
    localparam logic [1:0] SEL_CMP_B = 2'd2;
    localparam logic [1:0] SEL_CTRL  = 2'd3;

    localparam int NUM_CH = 2;

    typedef struct packed {
        logic inv_b;
        logic inv_a;
        logic phase;
        logic en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
    import pwm_slice_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [1:0]                 sel,
    input  logic [CW-1:0]              wdata,
    input  logic                       load,
    output ctrl_t                      ctrl,
    output logic [CW-1:0]              top_act,
    output logic [NUM_CH-1:0][CW-1:0]  cmp_act
);

    typedef struct packed {
        ctrl_t                      ctrl;
        logic [CW-1:0]              top_pend;
        logic [NUM_CH-1:0][CW-1:0]  cmp_pend;
        logic [CW-1:0]              top_act;
        logic [NUM_CH-1:0][CW-1:0]  cmp_act;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.top_act = st_q.top_pend;
            st_d.cmp_act = st_q.cmp_pend;
        end
        if (we) begin
            unique case (sel)
                SEL_TOP:   st_d.top_pend    = wdata;
                SEL_CMP_A: st_d.cmp_pend[0] = wdata;
                SEL_CMP_B: st_d.cmp_pend[1] = wdata;
                default:   st_d.ctrl        = ctrl_t'(wdata[CTRL_W-1:0]);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl    = st_q.ctrl;
    assign top_act = st_q.top_act;
    assign cmp_act = st_q.cmp_act;

    AST_ACTIVE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(top_act) && $stable(cmp_act))); // R9

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          phase,
    input  logic          tick,
    input  logic [CW-1:0] top,
    output logic [CW-1:0] cnt,
    output logic          wrap_evt,
    output logic          wrap_q
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          down;
        logic          wrap;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.wrap = 1'b0;
        if (!phase) st_d.down = 1'b0;
        if (en && tick) begin
            if (!phase) begin
                if (st_q.cnt >= top) begin
                    st_d.cnt  = '0;
                    st_d.wrap = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else if (!st_q.down) begin
                if (st_q.cnt >= top) st_d.down = 1'b1;
                else                 st_d.cnt  = st_q.cnt + 1'b1;
            end else begin
                if (st_q.cnt == '0) begin
                    st_d.down = 1'b0;
                    st_d.wrap = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt      = st_q.cnt;
    assign wrap_q   = st_q.wrap;
    assign wrap_evt = st_d.wrap;

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && tick) |=> $stable(cnt)); // R3
    AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_q |-> (cnt == '0)); // R10
    AST_NORMAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && !phase && cnt < top) |=> (cnt == $past(cnt) + 1'b1)); // R4

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          inv,
    input  logic [CW-1:0] cmp,
    input  logic [CW-1:0] cnt,
    output logic          pwm
);

    typedef struct packed {
        logic out;
    } ch_state_t;

    ch_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.out = en ? ((cmp > cnt) ^ inv) : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm = st_q.out;

    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm); // R8
    AST_CMP_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !inv && cmp == '0) |=> !pwm); // R7

endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
    import pwm_slice_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [CW-1:0] cfg_wdata,
    output logic [CW-1:0] count,
    output logic          pwm_a,
    output logic          pwm_b,
    output logic          wrap
);

    ctrl_t                     ctrl;
    logic [CW-1:0]             top_act;
    logic [NUM_CH-1:0][CW-1:0] cmp_act;
    logic [NUM_CH-1:0]         inv_vec;
    logic [NUM_CH-1:0]         pwm_vec;
    logic                      wrap_evt;
    logic                      load;

    assign load    = !ctrl.en || wrap_evt;
    assign inv_vec = {ctrl.inv_b, ctrl.inv_a};

    pwm_cfg_regs #(.CW(CW)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .wdata   (cfg_wdata),
        .load    (load),
        .ctrl    (ctrl),
        .top_act (top_act),
        .cmp_act (cmp_act)
    );

    pwm_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctrl.en),
        .phase    (ctrl.phase),
        .tick     (tick),
        .top      (top_act),
        .cnt      (count),
        .wrap_evt (wrap_evt),
        .wrap_q   (wrap)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        pwm_channel #(.CW(CW)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (ctrl.en),
            .inv   (inv_vec[ch]),
            .cmp   (cmp_act[ch]),
            .cnt   (count),
            .pwm   (pwm_vec[ch])
        );
    end

    assign pwm_a = pwm_vec[0];
    assign pwm_b = pwm_vec[1];

    AST_PHASE_TURN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.en && ctrl.phase && tick && $past(ctrl.en && ctrl.phase && tick)
         && count == top_act && $past(count) == top_act - 1'b1 && top_act != '0)
        |=> (count == $past(count))); // R5

endmodule

// File: tb/tb_pwm_slice.sv
module tb_pwm_slice;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [CW-1:0] cfg_wdata = '0;
    logic [CW-1:0] count;
    logic          pwm_a, pwm_b, wrap;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwm_slice #(.CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .count(count), .pwm_a(pwm_a), .pwm_b(pwm_b), .wrap(wrap)
    );

    // reference model state
    logic [CW-1:0] m_cnt, m_top, m_ca, m_cb, p_top, p_ca, p_cb;
    logic m_down, m_en, m_pc, m_ia, m_ib, m_pa, m_pb, m_wrap;

    task automatic model_reset();
        m_cnt = '0; m_top = '0; m_ca = '0; m_cb = '0;
        p_top = '0; p_ca = '0; p_cb = '0;
        m_down = 0; m_en = 0; m_pc = 0; m_ia = 0; m_ib = 0;
        m_pa = 0; m_pb = 0; m_wrap = 0;
    endtask

    function automatic logic chan_out(logic en, logic [CW-1:0] cmp,
                                      logic [CW-1:0] cnt, logic inv);
        return en ? ((cmp > cnt) ^ inv) : 1'b0;
    endfunction

    task automatic model_step(logic we, logic [1:0] sel, logic [CW-1:0] wd, logic tk);
        logic [CW-1:0] ncnt;
        logic ndown, load;
        m_pa = chan_out(m_en, m_ca, m_cnt, m_ia);
        m_pb = chan_out(m_en, m_cb, m_cnt, m_ib);
        m_wrap = 0;
        load = !m_en;
        ncnt = m_cnt;
        ndown = m_pc ? m_down : 1'b0;
        if (m_en && tk) begin
            if (!m_pc) begin
                if (m_cnt >= m_top) begin ncnt = '0; m_wrap = 1; load = 1; end
                else ncnt = m_cnt + 1'b1;
            end else if (!m_down) begin
                if (m_cnt >= m_top) ndown = 1;
                else ncnt = m_cnt + 1'b1;
            end else begin
                if (m_cnt == '0) begin ndown = 0; m_wrap = 1; load = 1; end
                else ncnt = m_cnt - 1'b1;
            end
        end
        if (load) begin m_top = p_top; m_ca = p_ca; m_cb = p_cb; end
        if (we) begin
            case (sel)
                2'd0: p_top = wd;
                2'd1: p_ca = wd;
                2'd2: p_cb = wd;
                default: {m_ib, m_ia, m_pc, m_en} = wd[3:0];
            endcase
        end
        m_cnt = ncnt;
        m_down = ndown;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R3/R4/R5 count", 32'(count), 32'(m_cnt));
        check("R6 pwm_a", 32'(pwm_a), 32'(m_pa));
        check("R6 pwm_b", 32'(pwm_b), 32'(m_pb));
        check("R10 wrap", 32'(wrap), 32'(m_wrap));
    endtask

    // one clock: drive at negedge, model at the edge, compare after it
    task automatic cyc(logic we, logic [1:0] sel, logic [CW-1:0] wd, logic tk);
        @(negedge clk);
        cfg_we = we; cfg_sel = sel; cfg_wdata = wd; tick = tk;
        @(posedge clk);
        #1;
        model_step(we, sel, wd, tk);
        compare_all();
    endtask

    task automatic wr(logic [1:0] sel, logic [CW-1:0] wd);
        cyc(1'b1, sel, wd, 1'b0);
    endtask

    task automatic run(int n, logic tk);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, '0, tk);
    endtask

    // measure clocks between two wrap pulses with tick held high
    task automatic measure_period(output int per);
        int guard;
        per = 0;
        guard = 0;
        while (!wrap && guard < 200) begin run(1, 1'b1); guard++; end
        run(1, 1'b1);
        per = 1;
        while (!wrap && per < 200) begin run(1, 1'b1); per++; end
    endtask

    initial begin
        int per, hi, lo, seed;
        logic [1:0] s;
        logic [CW-1:0] v;
        seed = 32'h5eed1234;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1: reset values
        check("R1 count", 32'(count), 0);
        check("R1 pwm_a", 32'(pwm_a), 0);
        check("R1 pwm_b", 32'(pwm_b), 0);
        check("R1 wrap", 32'(wrap), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2/R4 normal mode, top=4, period of 5 ticks
        wr(2'd0, 16'd4);
        wr(2'd1, 16'd2);
        wr(2'd2, 16'd5);
        wr(2'd3, 16'h1);
        measure_period(per);
        check("R4 normal period", 32'(per), 5);
        // R7: threshold B = top+1 keeps B high for a full period
        hi = 0;
        for (int i = 0; i < 5; i++) begin run(1, 1'b1); hi += int'(pwm_b); end
        check("R7 always high", 32'(hi), 5);

        // R5 phase-correct period 2*(top+1)
        wr(2'd3, 16'h3);
        measure_period(per);
        check("R5 phase period", 32'(per), 10);
        // R9: new top written mid-period only applies after a wrap
        wr(2'd0, 16'd2);
        measure_period(per);
        measure_period(per);
        check("R9 new top applied", 32'(per), 6);

        // R7: threshold 0 keeps A low
        wr(2'd1, 16'd0);
        measure_period(per);
        lo = 0;
        for (int i = 0; i < 6; i++) begin run(1, 1'b1); lo += int'(pwm_a); end
        check("R7 always low", 32'(lo), 0);

        // R6: inversion of A with threshold 0 gives always high
        wr(2'd3, 16'h7);
        run(2, 1'b1);
        check("R6 inverted A", 32'(pwm_a), 1);

        // R8: disabled with inversion set -> outputs low, count held (R3)
        wr(2'd3, 16'hC);
        v = count;
        run(4, 1'b1);
        check("R8 pwm_a off", 32'(pwm_a), 0);
        check("R8 pwm_b off", 32'(pwm_b), 0);
        check("R3 held when disabled", 32'(count), 32'(v));

        // R3: no tick, count held
        wr(2'd3, 16'h1);
        v = count;
        run(5, 1'b0);
        check("R3 held without tick", 32'(count), 32'(v));

        // constrained random
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 9) == 0) begin
                s = 2'($urandom_range(0, 3));
                if (s == 2'd0) v = 16'($urandom_range(0, 9));
                else if (s == 2'd3) v = 16'($urandom_range(0, 15) | (($urandom_range(0, 5) != 0) ? 1 : 0));
                else v = 16'($urandom_range(0, 11));
                cyc(1'b1, s, v, 1'($urandom_range(0, 2) != 0));
            end else begin
                cyc(1'b0, 2'd0, '0, 1'($urandom_range(0, 2) != 0));
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule